// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block is a byte-wide mailbox between a host processor bus and the internal bus of a small slave controller. The host writes a byte into an input holding register and reads a byte from an output holding register or an 8-bit status word. The slave reads the input register, writes the output register, and handles two handshake flags through single-cycle strobes. Input-full and output-full flags show which registers hold unconsumed bytes. Both flags are driven out as pins.

Every host write also stores the level of the host address line in flag 1. The slave can therefore tell a command byte (address high) from a data byte (address low). Flag 0 and four user bits are under slave control, and the host can read them through the status word. A host write raises a one-cycle interrupt pulse towards the slave. When DMA mode is on, a request line follows output-full, and an acknowledge acts as a data read with no decoding.

Top module: `hsm_mailbox`

## Requirements
- R1: After reset, input-full, output-full, flag 0, flag 1, the user bits, the interrupt and the DMA request are all 0, and a status read returns 0x00.
- R2: A host write (`h_sel` and `h_wr` high at a clock edge) loads `h_wdata` into the input register and sets input-full at that edge, and `s_irq` is high for exactly the following cycle.
- R3: At every host write, flag 1 takes the value of `h_addr` (1 marks a command, 0 marks data). This takes priority over a slave clear or complement of flag 1 in the same cycle.
- R4: A slave read strobe `s_rd_in` clears input-full, unless a host write happens in the same cycle, in which case input-full stays set.
- R5: A slave write `s_wr_out` loads `s_out_data` and sets output-full. A host data read (`h_sel`, `h_rd`, `h_addr`=0) returns the output register on `h_rdata` in the same cycle and clears output-full at the edge. A slave write in the same cycle wins and output-full stays set.
- R6: A host status read (`h_sel`, `h_rd`, `h_addr`=1) returns {user[3:0], flag 1, flag 0, input-full, output-full}, with output-full at bit 0 and user at bits 7:4. It changes no flag.
- R7: `s_f0_clr`/`s_f1_clr` clear flag 0/flag 1, and `s_f0_cpl`/`s_f1_cpl` invert it. When clear and complement come together, clear wins. The flags are visible on `s_f0`/`s_f1`.
- R8: `s_user_wr` loads `s_user_data` into the user bits, which appear in status bits 7:4.
- R9: `dma_req` is high exactly when `dma_mode` and output-full are both high. `dma_ack` returns the output register on `h_rdata` and clears output-full, whatever the values of `h_sel` and `h_addr`.
- R10: With `h_sel` low, `h_wr` and `h_rd` have no effect on any register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host chip select, active high |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 1 | Host address line: 0 data, 1 status/command |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (combinational) |
| dma_mode | input | 1 | Enables the DMA request |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, acts as a data read |
| s_rd_in | input | 1 | Slave reads input register |
| s_in_data | output | 8 | Input register contents |
| s_wr_out | input | 1 | Slave writes output register |
| s_out_data | input | 8 | Slave output byte |
| s_f0_clr | input | 1 | Clear flag 0 |
| s_f0_cpl | input | 1 | Complement flag 0 |
| s_f1_clr | input | 1 | Clear flag 1 |
| s_f1_cpl | input | 1 | Complement flag 1 |
| s_user_wr | input | 1 | Load user status bits |
| s_user_data | input | 4 | User status bits |
| s_f0 | output | 1 | Flag 0 for slave branch tests |
| s_f1 | output | 1 | Flag 1 for slave branch tests |
| s_irq | output | 1 | Interrupt pulse to slave after host write |
| in_full | output | 1 | Input-full pin |
| out_full | output | 1 | Output-full pin |

## Verification
Every flag, register, the interrupt pulse and the DMA request change at the clock edge that samples the strobe. So the bench compares them against its behavioural model at the falling edge that follows, one register stage after the stimulus. `h_rdata` is combinational on the current state and address. It is checked a short delay after the inputs are driven and before the edge that applies any read side effect. The colliding cases are each driven within a single cycle: write against slave read, slave write against host read, host write against flag-1 operation, and clear against complement. The resulting flag is then checked one edge later.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  // status word bit positions (the host decodes these)
  localparam int ST_OF = 0;
  localparam int ST_IF = 1;
  localparam int ST_F0 = 2;
  localparam int ST_F1 = 3;
  localparam int ST_USER_LO = 4;
endpackage

// File: rtl/hsm_flag.sv
// Single flag cell. Priority: set > load > clear > complement.
module hsm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic load_i,
  input  logic load_val_i,
  input  logic clr_i,
  input  logic cpl_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (load_i) q_o <= load_val_i;
    else if (clr_i)  q_o <= 1'b0;
    else if (cpl_i)  q_o <= ~q_o;
  end
endmodule

// File: rtl/hsm_dreg.sv
// Holding register with load enable.
module hsm_dreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/hsm_mailbox.sv
module hsm_mailbox #(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_sel,
  input  logic               h_rd,
  input  logic               h_wr,
  input  logic               h_addr,
  input  logic [DW-1:0]      h_wdata,
  output logic [DW-1:0]      h_rdata,
  input  logic               dma_mode,
  output logic               dma_req,
  input  logic               dma_ack,
  input  logic               s_rd_in,
  output logic [DW-1:0]      s_in_data,
  input  logic               s_wr_out,
  input  logic [DW-1:0]      s_out_data,
  input  logic               s_f0_clr,
  input  logic               s_f0_cpl,
  input  logic               s_f1_clr,
  input  logic               s_f1_cpl,
  input  logic               s_user_wr,
  input  logic [DW-5:0]      s_user_data,
  output logic               s_f0,
  output logic               s_f1,
  output logic               s_irq,
  output logic               in_full,
  output logic               out_full
);
  import hsm_pkg::*;
  localparam int UW = DW - ST_USER_LO;

  // named events, observed by the checker
  logic wr_evt, rd_data_evt, rd_stat_evt;
  assign wr_evt      = h_sel & h_wr;
  assign rd_data_evt = (h_sel & h_rd & ~h_addr) | dma_ack;
  assign rd_stat_evt = h_sel & h_rd & h_addr & ~dma_ack;

  logic [DW-1:0] out_q;
  logic [UW-1:0] user_q;
  logic [DW-1:0] status;

  function automatic logic [DW-1:0] pack_status(
    input logic [UW-1:0] u, input logic f1, input logic f0,
    input logic ifl, input logic ofl);
    logic [DW-1:0] s;
    s = '0;
    s[ST_OF] = ofl;
    s[ST_IF] = ifl;
    s[ST_F0] = f0;
    s[ST_F1] = f1;
    s[DW-1:ST_USER_LO] = u;
    return s;
  endfunction

  hsm_dreg #(.W(DW)) u_in_reg (
    .clk(clk), .rst_n(rst_n), .we_i(wr_evt), .d_i(h_wdata), .q_o(s_in_data));
  hsm_dreg #(.W(DW)) u_out_reg (
    .clk(clk), .rst_n(rst_n), .we_i(s_wr_out), .d_i(s_out_data), .q_o(out_q));
  hsm_dreg #(.W(UW)) u_user_reg (
    .clk(clk), .rst_n(rst_n), .we_i(s_user_wr), .d_i(s_user_data), .q_o(user_q));

  hsm_flag u_if (
    .clk(clk), .rst_n(rst_n), .set_i(wr_evt), .load_i(1'b0), .load_val_i(1'b0),
    .clr_i(s_rd_in), .cpl_i(1'b0), .q_o(in_full));
  hsm_flag u_of (
    .clk(clk), .rst_n(rst_n), .set_i(s_wr_out), .load_i(1'b0), .load_val_i(1'b0),
    .clr_i(rd_data_evt), .cpl_i(1'b0), .q_o(out_full));
  hsm_flag u_f0 (
    .clk(clk), .rst_n(rst_n), .set_i(1'b0), .load_i(1'b0), .load_val_i(1'b0),
    .clr_i(s_f0_clr), .cpl_i(s_f0_cpl), .q_o(s_f0));
  hsm_flag u_f1 (
    .clk(clk), .rst_n(rst_n), .set_i(1'b0), .load_i(wr_evt), .load_val_i(h_addr),
    .clr_i(s_f1_clr), .cpl_i(s_f1_cpl), .q_o(s_f1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_irq <= 1'b0;
    else        s_irq <= wr_evt;
  end

  assign status  = pack_status(user_q, s_f1, s_f0, in_full, out_full);
  assign h_rdata = (dma_ack | ~h_addr) ? out_q : status;
  assign dma_req = dma_mode & out_full;
endmodule

module hsm_mailbox_chk #(
  parameter int DW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic h_sel,
  input logic h_addr,
  input logic wr_evt,
  input logic rd_data_evt,
  input logic rd_stat_evt,
  input logic s_rd_in,
  input logic s_wr_out,
  input logic s_f0_clr,
  input logic s_f0_cpl,
  input logic s_f0,
  input logic s_f1,
  input logic s_irq,
  input logic in_full,
  input logic out_full,
  input logic dma_mode,
  input logic dma_req
);
  p_wr_sets_if_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> in_full);
  p_irq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> s_irq);
  p_irq_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_irq |-> in_full);
  p_f1_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (s_f1 == $past(h_addr)));
  p_rd_clears_if_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd_in && !wr_evt) |=> !in_full);
  p_wr_sets_of_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr_out |=> out_full);
  p_rd_clears_of_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_evt && !s_wr_out) |=> !out_full);
  p_stat_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_evt && !s_wr_out && !wr_evt && !s_rd_in)
      |=> ($stable(out_full) && $stable(in_full)));
  p_clr_f0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_f0_clr |=> !s_f0);
  p_cpl_f0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_f0_cpl && !s_f0_clr) |=> (s_f0 != $past(s_f0)));
  p_dma_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> !dma_req);
  p_nosel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_sel && !s_rd_in) |=> $stable(in_full));
endmodule

bind hsm_mailbox hsm_mailbox_chk #(.DW(DW)) u_chk (.*);

// File: tb/hsm_mailbox_test.sv
module hsm_mailbox_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_sel = 0, h_rd = 0, h_wr = 0, h_addr = 0;
  logic [7:0] h_wdata = 0;
  logic [7:0] h_rdata;
  logic dma_mode = 0, dma_ack = 0;
  logic dma_req;
  logic s_rd_in = 0, s_wr_out = 0;
  logic [7:0] s_in_data;
  logic [7:0] s_out_data = 0;
  logic s_f0_clr = 0, s_f0_cpl = 0, s_f1_clr = 0, s_f1_cpl = 0;
  logic s_user_wr = 0;
  logic [3:0] s_user_data = 0;
  logic s_f0, s_f1, s_irq, in_full, out_full;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int m_in, m_out, m_user, m_if, m_of, m_f0, m_f1, m_irq;

  always #(CLK_P/2) clk = ~clk;

  hsm_mailbox uut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in = 0; m_out = 0; m_user = 0; m_if = 0; m_of = 0;
      m_f0 = 0; m_f1 = 0; m_irq = 0;
    end else begin
      bit host_w, data_r;
      host_w = h_sel && h_wr;
      data_r = dma_ack || (h_sel && h_rd && !h_addr);
      m_irq = host_w;
      if (host_w) m_in = h_wdata;
      if (s_wr_out) m_out = s_out_data;
      if (s_user_wr) m_user = s_user_data;
      if (host_w) m_if = 1; else if (s_rd_in) m_if = 0;
      if (s_wr_out) m_of = 1; else if (data_r) m_of = 0;
      if (s_f0_clr) m_f0 = 0; else if (s_f0_cpl) m_f0 = 1 - m_f0;
      if (host_w) m_f1 = h_addr;
      else if (s_f1_clr) m_f1 = 0;
      else if (s_f1_cpl) m_f1 = 1 - m_f1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int status_word();
    return m_of + 2*m_if + 4*m_f0 + 8*m_f1 + 16*m_user;
  endfunction

  task automatic idle();
    h_sel = 0; h_rd = 0; h_wr = 0; h_addr = 0; dma_ack = 0;
    s_rd_in = 0; s_wr_out = 0; s_f0_clr = 0; s_f0_cpl = 0;
    s_f1_clr = 0; s_f1_cpl = 0; s_user_wr = 0;
  endtask

  // inputs already driven: check read mux, clock once, check state
  task automatic tick();
    #1;
    if (dma_ack || !h_addr) chk("R5/R9 data read", h_rdata, m_out);
    else                    chk("R6 status read", h_rdata, status_word());
    @(posedge clk);
    @(negedge clk);
    chk("R4 in_full", in_full, m_if);
    chk("R5 out_full", out_full, m_of);
    chk("R7 flag0", s_f0, m_f0);
    chk("R3 flag1", s_f1, m_f1);
    chk("R2 irq", s_irq, m_irq);
    chk("R2 in_data", s_in_data, m_in);
    chk("R9 dma_req", dma_req, (dma_mode && m_of) ? 1 : 0);
    idle();
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 in_full", in_full, 0);
    chk("R1 out_full", out_full, 0);
    chk("R1 irq/dma", {s_irq, dma_req, s_f0, s_f1}, 0);
    h_sel = 1; h_rd = 1; h_addr = 1; #1;
    chk("R1 status", h_rdata, 0);
    tick();
    // R2 data write, then R4 slave read
    h_sel = 1; h_wr = 1; h_addr = 0; h_wdata = 8'h5a; tick();
    chk("R2 irq one cycle", s_irq, 1);
    tick();
    chk("R2 irq drops", s_irq, 0);
    s_rd_in = 1; tick();
    chk("R4 cleared", in_full, 0);
    // R3 command write
    h_sel = 1; h_wr = 1; h_addr = 1; h_wdata = 8'hc3; tick();
    chk("R3 cmd flag", s_f1, 1);
    // R10 write without select
    h_wr = 1; h_addr = 0; h_wdata = 8'hff; tick();
    chk("R10 in_data kept", s_in_data, 8'hc3);
    h_rd = 1; s_wr_out = 1; s_out_data = 8'h11; tick();
    h_rd = 1; tick();
    chk("R10 out_full kept", out_full, 1);
    // R4 collision: write wins over slave read
    h_sel = 1; h_wr = 1; h_addr = 0; h_wdata = 8'h22; s_rd_in = 1; tick();
    chk("R4 write wins", in_full, 1);
    chk("R3 data flag", s_f1, 0);
    // R6 status read no side effects
    s_user_wr = 1; s_user_data = 4'ha; tick();
    h_sel = 1; h_rd = 1; h_addr = 1; #1;
    chk("R8 user bits", h_rdata, 8'ha3);
    tick();
    chk("R6 of kept", out_full, 1);
    chk("R6 if kept", in_full, 1);
    // R5 host data read
    h_sel = 1; h_rd = 1; h_addr = 0; #1;
    chk("R5 data", h_rdata, 8'h11);
    tick();
    chk("R5 cleared", out_full, 0);
    // R5 collision
    s_wr_out = 1; s_out_data = 8'h33; tick();
    h_sel = 1; h_rd = 1; h_addr = 0; s_wr_out = 1; s_out_data = 8'h44; tick();
    chk("R5 set wins", out_full, 1);
    // R7 flag ops
    s_f0_cpl = 1; tick();
    chk("R7 cpl", s_f0, 1);
    s_f0_cpl = 1; s_f0_clr = 1; tick();
    chk("R7 clr wins", s_f0, 0);
    s_f1_cpl = 1; tick();
    chk("R7 f1 cpl", s_f1, 1);
    s_f1_clr = 1; tick();
    // R3 priority over slave op
    h_sel = 1; h_wr = 1; h_addr = 1; h_wdata = 8'h01; s_f1_clr = 1; tick();
    chk("R3 host wins", s_f1, 1);
    // R9 DMA
    tick();
    chk("R9 no req when off", dma_req, 0);
    dma_mode = 1; #1;
    chk("R9 req", dma_req, 1);
    dma_ack = 1; h_addr = 1; #1;
    chk("R9 ack data", h_rdata, 8'h44);
    tick();
    chk("R9 ack clears", out_full, 0);
    chk("R9 req drops", dma_req, 0);
    s_wr_out = 1; s_out_data = 8'h77; tick();
    dma_mode = 0; tick();
    repeat (3) tick();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule